// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a mode-0 SPI slave that lets an external master read and write a small bank of 8-bit registers through a 5-bit address. The chip-select, serial clock and serial data input are brought into the system clock domain by synchronisers. A sequencing state machine then decodes the bytes that arrive. The first byte of every command holds a direction flag in its top bit and the register address in its low five bits. At the end of each byte, the register named by the most recent command is copied into the output shift register. The master therefore always receives the answer one byte later than the command that asked for it.

A write is held back until chip-select is released. It reaches the register only when the frame carried exactly one write command followed by one data byte. Control registers sit at the bottom of the address space. A window of read-only addresses shows bytes supplied by an external status unit. On every read command the block emits a one-cycle strobe with the address. The status unit can use it to clear latched flags once they have been reported.

The sequencer has four states. SEQ_IDLE is held while chip-select is high. SEQ_CMD expects a command byte. SEQ_WDATA expects the data byte of a write. SEQ_WDONE absorbs any bytes that follow. The transitions are as follows:
- SEQ_IDLE to SEQ_CMD when chip-select is seen low.
- SEQ_CMD stays in SEQ_CMD after a read command.
- SEQ_CMD to SEQ_WDATA after a write command.
- SEQ_WDATA to SEQ_WDONE when the data byte is complete.
- Any state to SEQ_IDLE when chip-select is seen high.

Top module: `spi_regport`

## Requirements
- R1: Mode 0. The data input is sampled on the rising serial-clock edge. The data output changes only after a falling serial-clock edge. The serial clock idles low and chip-select is active low.
- R2: Bytes travel MSB first. In a command byte, bit 7 = 1 means write and bit 7 = 0 means read. Bits 4:0 are the address. Bits 6:5 are ignored.
- R3: At the falling edge that ends every 8th bit of a frame, the output shift register is loaded with the register at the address of the last command received. That value is shifted out, MSB first, during the next byte. Between loads, each falling edge shifts the register left by one bit and fills with 0.
- R4: After a read command, the next byte is decoded as a new command. Chip-select may stay low across any number of reads.
- R5: A write is committed to its control register when chip-select is seen high. It is committed only if the frame carried exactly 16 bits and the first byte was a write command.
- R6: A frame of any other length is discarded, and so is a frame whose write command is not its first byte. Neither changes any register.
- R7: A write to an address at or above the number of control registers (default 4) leaves every register unchanged.
- R8: During the data byte of a write, the old contents of the addressed register are returned. A read-back sent straight after the write returns the old contents again during its command byte and the new value in the byte that follows.
- R9: After reset, all control registers are zero.
- R10: Each read command produces a one-cycle read strobe, with the read address on the address output.
- R11: Address map: addresses 0 to 3 are control registers. Addresses 4 to 7 return status byte k = address-4, taken from status input bits [8k+7:8k]. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| status_in | input | 32 | Four status bytes from the status unit |
| miso | output | 1 | Serial data to the master |
| ctrl_out | output | 32 | Control registers, register i in bits [8i+7:8i] |
| rd_stb | output | 1 | One-cycle pulse per read command |
| rd_addr | output | 5 | Address of the latest command |

## Verification
Two functions can fall in the same system-clock cycle: the final byte-end load of the output register and the write commit on chip-select release. The bench provokes this by raising chip-select at the same instant as the last serial-clock fall, in about half of all frames. Both synchronisers have equal depth, so the two events are detected in one cycle. The judgement comes from the next frame's first returned byte, which must still be the pre-write value, and from the control outputs, which must show the new value only when the frame was exactly 16 bits.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CMD,
        SEQ_WDATA,
        SEQ_WDONE
    } seq_state_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_regport_seq.sv
module spi_regport_seq
    import spi_regport_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 5,
    parameter int FRAME_BITS = 16,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1),
    localparam int BCNT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              ck_s,
    input  logic              di_s,
    output logic              ck_fall,
    output logic              load,
    output logic              shift,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              rd_stb,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);

    seq_state_e          state, nxt;
    logic                ck_p;
    logic                ck_rise;
    logic                active;
    logic                byte_done;
    logic [BCNT_W-1:0]   bcnt;
    logic [DATA_W-2:0]   rx;
    logic [DATA_W-1:0]   rx_next;

    assign ck_rise   = ck_s & ~ck_p;
    assign ck_fall   = ~ck_s & ck_p;
    assign active    = (state != SEQ_IDLE);
    assign rx_next   = {rx, di_s};
    assign byte_done = active && ck_rise && (bcnt == BCNT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (!cs_s) nxt = SEQ_CMD;
            SEQ_CMD: begin
                if (cs_s) nxt = SEQ_IDLE;
                else if (byte_done && rx_next[DATA_W-1]) nxt = SEQ_WDATA;
            end
            SEQ_WDATA: begin
                if (cs_s) nxt = SEQ_IDLE;
                else if (byte_done) nxt = SEQ_WDONE;
            end
            SEQ_WDONE: if (cs_s) nxt = SEQ_IDLE;
            default:   nxt = SEQ_IDLE;
        endcase
    end

    // frame datapath: bit counters, receive shifter, pointer, held write data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_p    <= 1'b0;
            rd_stb  <= 1'b0;
            cnt     <= '0;
            ovf     <= 1'b0;
            bcnt    <= '0;
            rx      <= '0;
            ptr     <= '0;
            wr_data <= '0;
        end else begin
            ck_p   <= ck_s;
            rd_stb <= 1'b0;
            if (state == SEQ_IDLE) begin
                cnt  <= '0;
                ovf  <= 1'b0;
                bcnt <= '0;
            end else if (ck_rise) begin
                rx   <= rx_next[DATA_W-2:0];
                bcnt <= (bcnt == BCNT_W'(DATA_W - 1)) ? '0 : bcnt + 1'b1;
                if (cnt == CNT_W'(FRAME_BITS)) ovf <= 1'b1;
                else                           cnt <= cnt + 1'b1;
                if (byte_done && state == SEQ_CMD) begin
                    ptr <= rx_next[ADDR_W-1:0];
                    if (!rx_next[DATA_W-1]) rd_stb <= 1'b1;
                end
                if (byte_done && state == SEQ_WDATA) wr_data <= rx_next;
            end
        end
    end

    // outputs
    always_comb begin
        load  = active && ck_fall && (bcnt == '0) && (cnt != '0);
        shift = active && ck_fall && !load;
        wr_en = (state == SEQ_WDONE) && cs_s && !ovf && (cnt == CNT_W'(FRAME_BITS));
    end

endmodule

// File: rtl/spi_regport_txsr.sv
module spi_regport_txsr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] load_val,
    output logic              miso
);

    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_val;
        else if (shift) sr <= {sr[DATA_W-2:0], 1'b0};
    end

    assign miso = sr[DATA_W-1];

endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int NUM_CTRL  = 4,
    parameter int STAT_BASE = 4,
    parameter int NUM_STAT  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NUM_STAT*DATA_W-1:0]   status_in,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_CTRL*DATA_W-1:0]   ctrl_out
);

    logic [DATA_W-1:0] ctrl [NUM_CTRL];

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              ctrl[g] <= '0;
            else if (wr_en && addr == ADDR_W'(g))    ctrl[g] <= wr_data;
        end
        assign ctrl_out[g*DATA_W +: DATA_W] = ctrl[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (addr == ADDR_W'(i)) rd_data = ctrl[i];
        for (int j = 0; j < NUM_STAT; j++)
            if (addr == ADDR_W'(STAT_BASE + j)) rd_data = status_in[j*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int NUM_CTRL    = 4,
    parameter int STAT_BASE   = 4,
    parameter int NUM_STAT    = 4,
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       mosi,
    input  logic [NUM_STAT*DATA_W-1:0] status_in,
    output logic                       miso,
    output logic [NUM_CTRL*DATA_W-1:0] ctrl_out,
    output logic                       rd_stb,
    output logic [ADDR_W-1:0]          rd_addr
);

    logic              cs_s, ck_s, di_s;
    logic              ck_fall, load, shift, wr_en, ovf;
    logic [DATA_W-1:0] wr_data, load_val;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  cnt;

    spi_regport_sync #(
        .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cs_n, sclk, mosi}),
        .dout({cs_s, ck_s, di_s})
    );

    spi_regport_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_BITS(FRAME_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .ck_s(ck_s), .di_s(di_s),
        .ck_fall(ck_fall), .load(load), .shift(shift),
        .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
        .rd_stb(rd_stb), .cnt(cnt), .ovf(ovf)
    );

    spi_regport_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL),
        .STAT_BASE(STAT_BASE), .NUM_STAT(NUM_STAT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
        .status_in(status_in), .rd_data(load_val), .ctrl_out(ctrl_out)
    );

    spi_regport_txsr #(.DATA_W(DATA_W)) u_txsr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .shift(shift), .load_val(load_val), .miso(miso)
    );

    assign rd_addr = ptr;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 5,
    parameter int NUM_CTRL   = 4,
    parameter int FRAME_BITS = 16,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_s,
    input logic                       ck_fall,
    input logic                       miso,
    input logic                       load,
    input logic [DATA_W-1:0]          load_val,
    input logic [NUM_CTRL*DATA_W-1:0] ctrl_out,
    input logic                       rd_stb,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [CNT_W-1:0]           cnt,
    input logic                       ovf
);

    assert_do_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(ck_fall));

    assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (miso == $past(load_val[DATA_W-1])));

    assert_commit_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_out) |-> ($past(cs_s) && !$past(ovf) && $past(cnt) == CNT_W'(FRAME_BITS)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cs_s) |=> ovf);

    assert_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NUM_CTRL) |=> $stable(ctrl_out));

    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

endmodule

bind spi_regport spi_regport_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ck_fall(ck_fall), .miso(miso),
    .load(load), .load_val(load_val), .ctrl_out(ctrl_out), .rd_stb(rd_stb),
    .wr_en(wr_en), .wr_addr(ptr), .cnt(cnt), .ovf(ovf)
);

// File: tb/sim_spi_regport.sv
`timescale 1ns/1ps
module sim_spi_regport;

    localparam int HALF = 8;   // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic [31:0] status_in = '0;
    logic        miso;
    logic [31:0] ctrl_out;
    logic        rd_stb;
    logic [4:0]  rd_addr;

    int errors = 0;
    int checks = 0;

    // bench model of the requirements
    logic [7:0] m_ctrl [4];
    logic [7:0] m_tx = '0;
    bit         m_tx_ok = 0;
    logic [4:0] m_ptr = '0;
    bit         m_ptr_ok = 0;
    int         rd_expect = 0;
    logic [4:0] last_rd_model = '0;
    int         stb_cnt = 0;
    logic [4:0] stb_addr = '0;

    always #4 clk = ~clk;

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .status_in(status_in), .miso(miso), .ctrl_out(ctrl_out),
        .rd_stb(rd_stb), .rd_addr(rd_addr)
    );

    always @(posedge clk) begin
        if (rd_stb) begin
            stb_cnt  <= stb_cnt + 1;
            stb_addr <= rd_addr;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_model(input logic [4:0] a);
        if (a < 5'd4)       return m_ctrl[a[1:0]];
        else if (a < 5'd8)  return status_in[(int'(a) - 4) * 8 +: 8];
        else                return 8'h00;
    endfunction

    function automatic logic [31:0] ctrl_model();
        return {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]};
    endfunction

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    // one chip-select window; bits sent MSB first from bit nb-1 downward
    task automatic frame(input int nb, input logic [31:0] bits, input bit late_cs, input string tag);
        int         st = 0;       // 0 command, 1 write data, 2 done
        int         cnt = 0;
        bit         ovf = 0;
        logic [7:0] rx = '0;
        logic [7:0] wdata = '0;
        logic [7:0] got = '0;
        logic [7:0] expb = '0;
        bit         known = 0;
        status_in = $urandom;
        half();
        cs_n = 1'b0;
        half();
        for (int i = 0; i < nb; i++) begin
            if (i % 8 == 0) known = m_tx_ok;
            mosi = bits[nb-1-i];
            half();
            sclk = 1'b1;
            got  = {got[6:0], miso};
            expb = {expb[6:0], m_tx[7]};
            rx   = {rx[6:0], bits[nb-1-i]};
            if (cnt == 16) ovf = 1; else cnt++;
            if (i % 8 == 7) begin
                if (st == 0) begin
                    m_ptr = rx[4:0];
                    m_ptr_ok = 1;
                    if (rx[7]) st = 1;
                    else begin
                        rd_expect++;
                        last_rd_model = rx[4:0];
                    end
                end else if (st == 1) begin
                    wdata = rx;
                    st = 2;
                end
                if (known) chk(got == expb, {tag, " R3 returned byte"}, 64'(got), 64'(expb));
            end
            half();
            sclk = 1'b0;
            if (late_cs && i == nb - 1) cs_n = 1'b1;
            if (i % 8 == 7) begin
                m_tx = rd_model(m_ptr);
                m_tx_ok = m_ptr_ok;
            end else begin
                m_tx = {m_tx[6:0], 1'b0};
            end
        end
        if (!late_cs) begin
            half();
            cs_n = 1'b1;
        end
        if (st == 2 && cnt == 16 && !ovf && m_ptr < 5'd4) m_ctrl[m_ptr[1:0]] = wdata;
        repeat (10) @(negedge clk);
        chk(ctrl_out == ctrl_model(), {tag, " control registers"}, 64'(ctrl_out), 64'(ctrl_model()));
        chk(stb_cnt == rd_expect, "R10 read strobe count", 64'(stb_cnt), 64'(rd_expect));
        if (rd_expect > 0) chk(stb_addr == last_rd_model, "R10 read strobe address", 64'(stb_addr), 64'(last_rd_model));
    endtask

    function automatic logic [7:0] rcmd(input logic [4:0] a);
        return {1'b0, 2'($urandom), a};
    endfunction

    function automatic logic [7:0] wcmd(input logic [4:0] a);
        return {1'b1, 2'($urandom), a};
    endfunction

    initial begin
        int lens [6] = '{8, 12, 15, 17, 20, 24};
        void'($urandom(32'd20250611));
        for (int k = 0; k < 4; k++) m_ctrl[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(ctrl_out == 32'h0, "R9 reset control registers", 64'(ctrl_out), 64'h0);

        // R5 write committed while the last byte-end load coincides with CS release
        frame(16, {16'h0, 8'h80, 8'hA5}, 1'b1, "R5 write");
        // R8 read-back: old value during command byte, new value after
        frame(16, {16'h0, 8'h00, 8'h01}, 1'b0, "R8 readback");
        // R6 short write discarded
        frame(12, {20'h0, 8'h81, 4'h7}, 1'b0, "R6 short");
        // R6 long write discarded
        frame(24, {8'h0, 8'h81, 8'h3C, 8'hFF}, 1'b1, "R6 long");
        // R7 write to a status address
        frame(16, {16'h0, 8'h85, 8'h5A}, 1'b0, "R7 readonly");
        // R11 status window and unmapped address, R4 chained reads
        frame(24, {8'h0, 8'h06, 8'h14, 8'h00}, 1'b0, "R11 map");
        // R2 bits 6:5 of a command are ignored
        frame(16, {16'h0, 8'hE2, 8'h3E}, 1'b0, "R2 cmd bits");
        frame(16, {16'h0, 8'h62, 8'h00}, 1'b0, "R2 readback");

        for (int n = 0; n < 60; n++) begin
            int kind = $urandom_range(0, 3);
            bit late = 1'($urandom_range(0, 1));
            case (kind)
                0: frame(16, {16'h0, wcmd(5'($urandom_range(0, 7))), 8'($urandom)}, late, "R5 random write");
                1: begin
                    int nby = $urandom_range(1, 3);
                    logic [31:0] b = '0;
                    for (int k = 0; k < nby; k++) begin
                        logic [4:0] a = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'($urandom_range(0, 7));
                        b = {b[23:0], rcmd(a)};
                    end
                    frame(8 * nby, b, late, "R4 random reads");
                end
                2: begin
                    int nb = lens[$urandom_range(0, 5)];
                    logic [31:0] b = $urandom;
                    b[nb-1] = 1'b1;
                    frame(nb, b, late, "R6 random length");
                end
                default: frame(24, {8'h0, rcmd(5'($urandom_range(0, 7))), wcmd(5'($urandom_range(0, 3))), 8'($urandom)},
                               late, "R6 late write");
            endcase
        end

        summary();
        $finish;
    end

endmodule